// File: doc/BRIEF.md
# Four-Pass Vector Execution Unit

This block executes one integer vector instruction over a 64-element vector of 32-bit elements on a datapath that is only 16 lanes wide. It does so in four back-to-back passes: pass k reads, computes and writes back elements 16k through 16k+15, in ascending pass order. The unit holds its own register file of 256 vector registers. Each register is stored as four rows of 16 elements, and row k holds the elements of pass k.

An issue request names an opcode, a destination register, two source registers and a 64-bit execute mask. The request is taken only while the unit is idle. The unit then raises busy for exactly four cycles and pulses done for one cycle once the last pass has been written back. Lanes whose mask bit is clear keep their old destination value.

A row-wide fill port lets the neighbouring load path place data into the register file while the unit is idle. A combinational row read port lets that path take results out.

Top module: `vec_multipass_unit`

## Requirements
- R1: Opcode 0 adds, 1 subtracts (source A minus source B), 2 ANDs, 3 ORs, 4 XORs and 5 copies source A. Each opcode acts element-wise on 32-bit elements, and sums and differences wrap modulo 2^32.
- R2: Opcodes 6 and 7 leave every element of the destination unchanged, while still taking the full four-pass timing.
- R3: An issue is accepted when busy is low. Busy is high from the cycle after acceptance for exactly four cycles, and pass k covers elements 16k..16k+15. Element 16k+j sits at bits [32j+31:32j] of row k.
- R4: done is high for exactly one cycle. That cycle is the first cycle with busy low after the fourth pass has been written back.
- R5: An issue request made while busy is high is ignored. It neither changes any register nor extends or restarts the busy period.
- R6: Bit i of the execute mask, sampled at issue, enables element i. A masked-off element keeps its previous destination value.
- R7: When the destination equals one or both sources, the result equals the operation applied to the pre-instruction source values.
- R8: The fill port writes fillData into row fillPass of register fillReg at the clock edge when fillEn is high and busy is low. A fill request made while busy is high is ignored.
- R9: peekData shows row peekPass of register peekReg combinationally, with the same element layout as R3.
- R10: A synchronous active-high reset clears busy and done, including in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueValid | input | 1 | Issue request |
| issueOp | input | 3 | Opcode (R1, R2) |
| issueDst | input | 8 | Destination register |
| issueSrcA | input | 8 | First source register |
| issueSrcB | input | 8 | Second source register |
| issueMask | input | 64 | Per-element execute mask |
| busy | output | 1 | Passes remain |
| done | output | 1 | One-cycle completion pulse |
| fillEn | input | 1 | Row fill request |
| fillReg | input | 8 | Register to fill |
| fillPass | input | 2 | Row within register to fill |
| fillData | input | 512 | Row fill data |
| peekReg | input | 8 | Register to read |
| peekPass | input | 2 | Row within register to read |
| peekData | output | 512 | Row read data |

## Verification
The timing assertions take for granted that reset is held for at least one clock edge before the first request. They also assume that nothing but issueValid can start a busy period. Every opcode, operand and mask field is sampled only at acceptance, so the properties place no constraint on those fields. The stimulus therefore drives arbitrary values into them, and on purpose raises issueValid and fillEn while busy is high. Inputs change only on the falling edge, so every request is stable across the rising edge that samples it.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;
  localparam logic [2:0] OP_MOV = 3'd5;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchInstr;
    logic writeEn;
    logic fillWe;
  } vmuCtrlS;
endpackage

// File: rtl/vmu_lane_alu.sv
module vmu_lane_alu
  import vmu_pkg::*;
#(
  parameter int ELEM_W = 32
) (
  input  logic [2:0]        op,
  input  logic              laneEn,
  input  logic [ELEM_W-1:0] srcA,
  input  logic [ELEM_W-1:0] srcB,
  input  logic [ELEM_W-1:0] oldVal,
  output logic [ELEM_W-1:0] result
);
  logic [ELEM_W-1:0] opRes;

  always_comb begin
    case (op)
      OP_ADD:  opRes = srcA + srcB;
      OP_SUB:  opRes = srcA - srcB;
      OP_AND:  opRes = srcA & srcB;
      OP_OR:   opRes = srcA | srcB;
      OP_XOR:  opRes = srcA ^ srcB;
      OP_MOV:  opRes = srcA;
      default: opRes = oldVal;
    endcase
    result = laneEn ? opRes : oldVal;
  end
endmodule

// File: rtl/vmu_ctrl.sv
module vmu_ctrl
  import vmu_pkg::*;
#(
  parameter int PASSES = 4,
  localparam int PASS_W = $clog2(PASSES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  input  logic              fillEn,
  output logic              busy,
  output logic              done,
  output logic [PASS_W-1:0] passIdx,
  output vmuCtrlS           ctrl
);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      passIdx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        passIdx <= '0;
        if (issueValid) busy <= 1'b1;
      end else begin
        passIdx <= passIdx + 1'b1;
        if (passIdx == LAST_PASS) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl.latchInstr = issueValid & ~busy;
    ctrl.writeEn    = busy;
    ctrl.fillWe     = fillEn & ~busy;
  end
endmodule

// File: rtl/vmu_datapath.sv
module vmu_datapath
  import vmu_pkg::*;
#(
  parameter int LANES    = 16,
  parameter int PASSES   = 4,
  parameter int ELEM_W   = 32,
  parameter int NUM_REGS = 256,
  localparam int PASS_W  = $clog2(PASSES),
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int ROW_W   = LANES * ELEM_W,
  localparam int VEC_N   = LANES * PASSES,
  localparam int ROWS    = NUM_REGS * PASSES
) (
  input  logic              clk,
  input  vmuCtrlS           ctrl,
  input  logic [PASS_W-1:0] passIdx,
  input  logic [2:0]        issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [VEC_N-1:0]  issueMask,
  input  logic [REG_W-1:0]  fillReg,
  input  logic [PASS_W-1:0] fillPass,
  input  logic [ROW_W-1:0]  fillData,
  input  logic [REG_W-1:0]  peekReg,
  input  logic [PASS_W-1:0] peekPass,
  output logic [ROW_W-1:0]  peekData
);
  logic [ROW_W-1:0] regRows [ROWS];

  logic [2:0]       opQ;
  logic [REG_W-1:0] dstQ, srcAQ, srcBQ;
  logic [VEC_N-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (ctrl.latchInstr) begin
      opQ   <= issueOp;
      dstQ  <= issueDst;
      srcAQ <= issueSrcA;
      srcBQ <= issueSrcB;
      maskQ <= issueMask;
    end
  end

  logic [ROW_W-1:0] rowA, rowB, rowOld, rowRes;
  logic [LANES-1:0] passMask;

  always_comb begin
    rowA     = regRows[{srcAQ, passIdx}];
    rowB     = regRows[{srcBQ, passIdx}];
    rowOld   = regRows[{dstQ, passIdx}];
    passMask = maskQ[passIdx * LANES +: LANES];
    peekData = regRows[{peekReg, peekPass}];
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    vmu_lane_alu #(.ELEM_W(ELEM_W)) alu_i (
      .op     (opQ),
      .laneEn (passMask[ln]),
      .srcA   (rowA[ln*ELEM_W +: ELEM_W]),
      .srcB   (rowB[ln*ELEM_W +: ELEM_W]),
      .oldVal (rowOld[ln*ELEM_W +: ELEM_W]),
      .result (rowRes[ln*ELEM_W +: ELEM_W])
    );
  end

  // all operands of a row are read in the cycle its result is written
  always_ff @(posedge clk) begin
    if (ctrl.writeEn)
      regRows[{dstQ, passIdx}] <= rowRes;
    else if (ctrl.fillWe)
      regRows[{fillReg, fillPass}] <= fillData;
  end
endmodule

// File: rtl/vec_multipass_unit.sv
module vec_multipass_unit
  import vmu_pkg::*;
#(
  parameter int LANES    = 16,
  parameter int PASSES   = 4,
  parameter int ELEM_W   = 32,
  parameter int NUM_REGS = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          issueValid,
  input  logic [2:0]                    issueOp,
  input  logic [$clog2(NUM_REGS)-1:0]   issueDst,
  input  logic [$clog2(NUM_REGS)-1:0]   issueSrcA,
  input  logic [$clog2(NUM_REGS)-1:0]   issueSrcB,
  input  logic [LANES*PASSES-1:0]       issueMask,
  output logic                          busy,
  output logic                          done,
  input  logic                          fillEn,
  input  logic [$clog2(NUM_REGS)-1:0]   fillReg,
  input  logic [$clog2(PASSES)-1:0]     fillPass,
  input  logic [LANES*ELEM_W-1:0]       fillData,
  input  logic [$clog2(NUM_REGS)-1:0]   peekReg,
  input  logic [$clog2(PASSES)-1:0]     peekPass,
  output logic [LANES*ELEM_W-1:0]       peekData
);
  localparam int PASS_W = $clog2(PASSES);

  vmuCtrlS           ctrl;
  logic [PASS_W-1:0] passIdx;

  vmu_ctrl #(.PASSES(PASSES)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .fillEn     (fillEn),
    .busy       (busy),
    .done       (done),
    .passIdx    (passIdx),
    .ctrl       (ctrl)
  );

  vmu_datapath #(
    .LANES(LANES), .PASSES(PASSES), .ELEM_W(ELEM_W), .NUM_REGS(NUM_REGS)
  ) dp_i (
    .clk       (clk),
    .ctrl      (ctrl),
    .passIdx   (passIdx),
    .issueOp   (issueOp),
    .issueDst  (issueDst),
    .issueSrcA (issueSrcA),
    .issueSrcB (issueSrcB),
    .issueMask (issueMask),
    .fillReg   (fillReg),
    .fillPass  (fillPass),
    .fillData  (fillData),
    .peekReg   (peekReg),
    .peekPass  (peekPass),
    .peekData  (peekData)
  );
endmodule

// File: rtl/vmu_checker.sv
module vmu_checker #(
  parameter int PASSES = 4
) (
  input logic clk,
  input logic rst,
  input logic issueValid,
  input logic busy,
  input logic done
);
  localparam int RUN_W = $clog2(PASSES + 1) + 1;
  localparam logic [RUN_W-1:0] PASS_CNT  = RUN_W'(PASSES);
  localparam logic [RUN_W-1:0] LAST_CNT  = RUN_W'(PASSES - 1);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  AST_START_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (issueValid && !busy) |=> busy);                          // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < PASS_CNT));                               // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (!busy && run != '0) |-> (run == PASS_CNT));              // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                          // R4
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && run == PASS_CNT));                     // R4
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && run == LAST_CNT) |=> !busy);                     // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!busy && !done));                                // R10
endmodule

bind vec_multipass_unit vmu_checker #(.PASSES(PASSES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .issueValid (issueValid),
  .busy       (busy),
  .done       (done)
);

// File: tb/vec_multipass_unit_tb_top.sv
module vec_multipass_unit_tb_top;
  import vmu_pkg::*;

  localparam int NREG_USED = 8;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  dst;
    logic [7:0]  sa;
    logic [7:0]  sb;
    logic [63:0] mask;
  } vecT;

  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vecT TBL [0:10] = '{
    '{OP_ADD, 8'd2, 8'd0, 8'd1, ALL},
    '{OP_SUB, 8'd3, 8'd0, 8'd1, ALL},
    '{OP_SUB, 8'd4, 8'd1, 8'd0, 64'hF0F0_F0F0_0F0F_0F0F},
    '{OP_AND, 8'd5, 8'd0, 8'd1, ALL},
    '{OP_OR,  8'd6, 8'd2, 8'd3, 64'h0123_4567_89AB_CDEF},
    '{OP_XOR, 8'd0, 8'd0, 8'd1, ALL},
    '{OP_MOV, 8'd7, 8'd5, 8'd0, 64'hFFFF_0000_0000_FFFF},
    '{3'd6,   8'd2, 8'd0, 8'd1, ALL},
    '{3'd7,   8'd3, 8'd1, 8'd1, ALL},
    '{OP_ADD, 8'd1, 8'd1, 8'd1, ALL},
    '{OP_AND, 8'd6, 8'd4, 8'd5, 64'h0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issueValid = 1'b0;
  logic [2:0]   issueOp = '0;
  logic [7:0]   issueDst = '0, issueSrcA = '0, issueSrcB = '0;
  logic [63:0]  issueMask = '0;
  logic         busy, done;
  logic         fillEn = 1'b0;
  logic [7:0]   fillReg = '0;
  logic [1:0]   fillPass = '0;
  logic [511:0] fillData = '0;
  logic [7:0]   peekReg = '0;
  logic [1:0]   peekPass = '0;
  logic [511:0] peekData;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NREG_USED][64];

  always #2 clk = ~clk;

  vec_multipass_unit dut_i (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueMask(issueMask), .busy(busy), .done(done), .fillEn(fillEn),
    .fillReg(fillReg), .fillPass(fillPass), .fillData(fillData),
    .peekReg(peekReg), .peekPass(peekPass), .peekData(peekData)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] seedVal(input int r, input int e);
    return 32'((r + 1) * 32'h9E37_79B1) ^ 32'(e * 32'h85EB_CA77) ^ {8'(r), 8'(e), 16'hA5C3};
  endfunction

  function automatic logic [31:0] refOp(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] old);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_MOV:  return a;
      default: return old;
    endcase
  endfunction

  task automatic fillRow(input int r, input int p);
    @(negedge clk);
    fillEn = 1'b1; fillReg = 8'(r); fillPass = 2'(p);
    for (int j = 0; j < 16; j++) fillData[32*j +: 32] = model[r][16*p + j];
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  // compares all rows of a register against the model
  task automatic compareReg(input int r, input string tag);
    for (int p = 0; p < 4; p++) begin
      logic [511:0] exp;
      peekReg = 8'(r); peekPass = 2'(p);
      #1;
      for (int j = 0; j < 16; j++) exp[32*j +: 32] = model[r][16*p + j];
      chk(peekData == exp, tag, peekData[63:0], exp[63:0]);
    end
  endtask

  task automatic runInstr(input vecT v, input bit busyIssue, input bit busyFill);
    logic [31:0] nxt [64];
    string tag;
    @(negedge clk);
    issueValid = 1'b1; issueOp = v.op; issueDst = v.dst;
    issueSrcA = v.sa; issueSrcB = v.sb; issueMask = v.mask;
    @(negedge clk);
    issueValid = 1'b0;
    issueOp = 3'h0; issueMask = '0;
    chk(busy && !done, "R3 busy after accept", {62'd0, busy, done}, 64'd2);
    if (busyIssue) begin
      issueValid = 1'b1; issueOp = OP_MOV; issueDst = 8'd3;
      issueSrcA = 8'd0; issueSrcB = 8'd0; issueMask = ALL;
    end
    if (busyFill) begin
      fillEn = 1'b1; fillReg = 8'd4; fillPass = 2'd1; fillData = '1;
    end
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      issueValid = 1'b0; fillEn = 1'b0;
      chk(busy && !done, "R3 busy during passes", {62'd0, busy, done}, 64'd2);
    end
    @(negedge clk);
    chk(!busy && done, "R4 done after last pass", {62'd0, busy, done}, 64'd1);
    @(negedge clk);
    chk(!busy && !done, busyIssue ? "R5 no restart" : "R4 done one cycle",
        {62'd0, busy, done}, 64'd0);
    for (int e = 0; e < 64; e++)
      nxt[e] = v.mask[e] ? refOp(v.op, model[v.sa][e], model[v.sb][e], model[v.dst][e])
                         : model[v.dst][e];
    for (int e = 0; e < 64; e++) model[v.dst][e] = nxt[e];
    if (v.op > OP_MOV)                       tag = "R2 undefined op";
    else if (v.dst == v.sa || v.dst == v.sb) tag = "R7 in-place";
    else if (v.mask != ALL)                  tag = "R6 masked";
    else                                     tag = "R1 op result";
    compareReg(int'(v.dst), tag);
    if (busyIssue) compareReg(3, "R5 ignored issue");
    if (busyFill)  compareReg(4, "R8 ignored fill");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG_USED; r++)
      for (int e = 0; e < 64; e++) model[r][e] = seedVal(r, e);
    model[1][0] = 32'hFFFF_FFFF;           // forces wrap on add
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R10 reset state", {62'd0, busy, done}, 64'd0);

    for (int r = 0; r < NREG_USED; r++)
      for (int p = 0; p < 4; p++) fillRow(r, p);
    @(negedge clk);
    compareReg(0, "R9 peek after fill");
    compareReg(1, "R8 fill row");

    for (int i = 0; i < 11; i++) runInstr(TBL[i], 1'b0, 1'b0);

    // requests during busy must be dropped
    runInstr('{OP_ADD, 8'd5, 8'd0, 8'd1, ALL}, 1'b1, 1'b1);

    // idle fill of a single row, visible at once on the peek port
    for (int j = 0; j < 16; j++) model[0][32 + j] = 32'hC0DE_0000 + 32'(j);
    fillRow(0, 2);
    compareReg(0, "R8 idle fill");

    // reset in the middle of an instruction
    @(negedge clk);
    issueValid = 1'b1; issueOp = OP_ADD; issueDst = 8'd7;
    issueSrcA = 8'd0; issueSrcB = 8'd1; issueMask = ALL;
    @(negedge clk);
    issueValid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done, "R10 reset mid-run", {62'd0, busy, done}, 64'd0);
    repeat (5) begin
      @(negedge clk);
      chk(!busy && !done, "R10 stays idle", {62'd0, busy, done}, 64'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule